// File: doc/BRIEF.md
# MAC Address Hash Filter

This block decides whether a 48-bit Ethernet destination address falls into a bin of a 64-bin hash table. The address is taken as six bytes, byte 0 on `addr_i[7:0]` and byte 5 on `addr_i[47:40]`. A reflected CRC-32 runs over those bytes, and the top six bits of the CRC register pick one of 64 table bits. The table is held in two 32-bit inputs: an upper half for bins 32 to 63 and a lower half for bins 0 to 31.

A computation starts with a one-cycle `start_i` while the block is idle. The CRC runs either one address bit per clock (48 steps) or one whole byte per clock (6 steps), as chosen by `byte_mode_i` at start. When it finishes, the block raises `done_o` for one cycle and updates the index and match outputs. A helper mode, chosen by `pattern_mode_i` at start, returns the single-bit 64-bit table image for the address instead of a match. Software can OR these images together to build a table.

Top module: `mac_hash_filter`

## Requirements
- R1: While `rst_ni` is low and after it rises with no start, `busy_o`, `done_o`, `match_o`, `index_o`, `pat_hi_o` and `pat_lo_o` are all zero.
- R2: The CRC register starts at all ones. It processes byte 0 (`addr_i[7:0]`) through byte 5, each byte least significant bit first. For each bit, if the data bit XOR crc[0] is 1, the register shifts right and is XORed with 0xEDB88320; otherwise it only shifts right. No final inversion is applied, and `index_o` is crc[31:26].
- R3: With `byte_mode_i` high at start, `done_o` rises 6 clock edges after the edge that accepts the start. With it low, this takes 48 edges. Both modes give the same index for the same address.
- R4: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after the accepting edge up to the last step, and it is low in the cycle where `done_o` is high.
- R5: In filter mode (`pattern_mode_i` low at start), `match_o` equals `tbl_hi_i[index-32]` when the index is 32 or more, and `tbl_lo_i[index]` otherwise. The table is sampled on the final step edge.
- R6: In pattern mode, exactly one bit of {`pat_hi_o`,`pat_lo_o`} is set. That bit is `pat_hi_o[index-32]` for an index of 32 or more and `pat_lo_o[index]` below 32. `match_o` is 0.
- R7: In filter mode, `pat_hi_o` and `pat_lo_o` are zero after `done_o`.
- R8: A `start_i` while `busy_o` is high is ignored. Changes of `addr_i`, `byte_mode_i` or `pattern_mode_i` during a run have no effect on its result, its latency, or on `busy_o` after it.
- R9: `index_o`, `match_o`, `pat_hi_o` and `pat_lo_o` change only on the edge that raises `done_o` and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| byte_mode_i | input | 1 | 1: one byte per clock, 0: one bit per clock |
| pattern_mode_i | input | 1 | 1: return table image, 0: test table |
| addr_i | input | 48 | Address, byte 0 in bits 7:0 |
| tbl_hi_i | input | 32 | Hash table bins 32 to 63 |
| tbl_lo_i | input | 32 | Hash table bins 0 to 31 |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| match_o | output | 1 | Selected table bit (filter mode) |
| index_o | output | 6 | Hash bin index crc[31:26] |
| pat_hi_o | output | 32 | Table image, upper half (pattern mode) |
| pat_lo_o | output | 32 | Table image, lower half (pattern mode) |

## Verification
Two things can fall into the same cycle: a new start request and the steps of a run already in progress. The bench drives this case by pulsing `start_i` with a different address and mode two cycles into a byte-mode run. It then checks three points: the result still matches the first address, the latency is still 6 edges, and `busy_o` stays low after `done_o`. The final step also fixes the outputs while the table inputs are live, so results are compared against a bench CRC model under vectors that cover both table halves and both stepping modes.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] crc,
                                                    input logic d);
    logic [CRC_W-1:0] sh;
    sh = crc >> 1;
    return (d ^ crc[0]) ? (sh ^ CRC_POLY) : sh;
  endfunction
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
  import mhf_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [LANE_W-1:0] data_i,
  output logic [CRC_W-1:0]  bit_o,
  output logic [CRC_W-1:0]  lane_o
);
  logic [CRC_W-1:0] chain [LANE_W+1];

  assign chain[0] = crc_i;
  for (genvar g = 0; g < LANE_W; g++) begin : g_stage
    assign chain[g+1] = crc_bit_step(chain[g], data_i[g]);
  end

  assign bit_o  = chain[1];
  assign lane_o = chain[LANE_W];
endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl #(
  parameter int unsigned SERIAL_STEPS = 48,
  parameter int unsigned BYTE_STEPS   = 6,
  localparam int unsigned CNT_W       = $clog2(SERIAL_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_mode_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             byte_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] SER_LAST  = CNT_W'(SERIAL_STEPS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_STEPS - 1);

  logic             busy_q, byte_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o   = start_i & ~busy_q;
  assign last_o   = busy_q & (cnt_q == (byte_q ? BYTE_LAST : SER_LAST));
  assign busy_o   = busy_q;
  assign byte_q_o = byte_q;
  assign cnt_o    = cnt_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      byte_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        byte_q <= byte_mode_i;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mhf_bin_select.sv
module mhf_bin_select #(
  parameter int unsigned TBL_W = 32,
  localparam int unsigned IDX_W = $clog2(2 * TBL_W)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TBL_W-1:0] tbl_hi_i,
  input  logic [TBL_W-1:0] tbl_lo_i,
  output logic             hit_o,
  output logic [TBL_W-1:0] onehot_hi_o,
  output logic [TBL_W-1:0] onehot_lo_o
);
  logic [2*TBL_W-1:0] tbl, onehot;

  assign tbl   = {tbl_hi_i, tbl_lo_i};
  assign hit_o = tbl[idx_i];

  for (genvar g = 0; g < 2 * TBL_W; g++) begin : g_dec
    assign onehot[g] = (idx_i == IDX_W'(g));
  end

  assign onehot_hi_o = onehot[2*TBL_W-1:TBL_W];
  assign onehot_lo_o = onehot[TBL_W-1:0];
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned TBL_W      = 32,
  localparam int unsigned ADDR_W    = ADDR_BYTES * 8,
  localparam int unsigned IDX_W     = $clog2(2 * TBL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_mode_i,
  input  logic              pattern_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TBL_W-1:0]  tbl_hi_i,
  input  logic [TBL_W-1:0]  tbl_lo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              match_o,
  output logic [IDX_W-1:0]  index_o,
  output logic [TBL_W-1:0]  pat_hi_o,
  output logic [TBL_W-1:0]  pat_lo_o
);
  localparam int unsigned CNT_W  = $clog2(ADDR_W);
  localparam int unsigned BSEL_W = $clog2(ADDR_BYTES);

  logic             load, last, byte_q, pat_q;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0] crc_q, crc_bit, crc_lane, crc_nxt;
  logic [7:0]       lanes [ADDR_BYTES];
  logic [7:0]       lane_cur;
  logic             hit;
  logic [TBL_W-1:0] oh_hi, oh_lo;
  logic [IDX_W-1:0] idx_nxt;
  logic             match_q;
  logic [IDX_W-1:0] index_q;
  logic [TBL_W-1:0] pat_hi_q, pat_lo_q;

  mhf_ctrl #(.SERIAL_STEPS(ADDR_W), .BYTE_STEPS(ADDR_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .byte_mode_i,
    .load_o(load), .busy_o, .last_o(last), .byte_q_o(byte_q),
    .cnt_o(cnt), .done_o
  );

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lanes[g] = addr_q[8*g +: 8];
  end

  // serial mode feeds only bit 0 of the lane, taken from the running bit index
  always_comb begin
    if (byte_q) lane_cur = lanes[cnt[BSEL_W-1:0]];
    else        lane_cur = {7'b0, addr_q[cnt]};
  end

  mhf_crc_step #(.LANE_W(8)) u_step (
    .crc_i(crc_q), .data_i(lane_cur), .bit_o(crc_bit), .lane_o(crc_lane)
  );

  assign crc_nxt = byte_q ? crc_lane : crc_bit;
  assign idx_nxt = crc_nxt[CRC_W-1 -: IDX_W];

  mhf_bin_select #(.TBL_W(TBL_W)) u_sel (
    .idx_i(idx_nxt), .tbl_hi_i, .tbl_lo_i,
    .hit_o(hit), .onehot_hi_o(oh_hi), .onehot_lo_o(oh_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      pat_q  <= 1'b0;
      crc_q  <= CRC_SEED;
    end else if (load) begin
      addr_q <= addr_i;
      pat_q  <= pattern_mode_i;
      crc_q  <= CRC_SEED;
    end else if (busy_o) begin
      crc_q <= crc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= 1'b0;
      index_q  <= '0;
      pat_hi_q <= '0;
      pat_lo_q <= '0;
    end else if (last) begin
      index_q  <= idx_nxt;
      match_q  <= ~pat_q & hit;
      pat_hi_q <= pat_q ? oh_hi : '0;
      pat_lo_q <= pat_q ? oh_lo : '0;
    end
  end

  assign match_o  = match_q;
  assign index_o  = index_q;
  assign pat_hi_o = pat_hi_q;
  assign pat_lo_o = pat_lo_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned TBL_W = 32,
  localparam int unsigned IDX_W = $clog2(2 * TBL_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             match_o,
  input logic [IDX_W-1:0] index_o,
  input logic [TBL_W-1:0] tbl_hi_i,
  input logic [TBL_W-1:0] tbl_lo_i,
  input logic [TBL_W-1:0] pat_hi_o,
  input logic [TBL_W-1:0] pat_lo_o
);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_match_bit_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && match_o) |-> ({tbl_hi_i, tbl_lo_i} >> index_o) & 64'd1);

  assert_pattern_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pat_hi_o, pat_lo_o}));

  assert_pattern_no_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({pat_hi_o, pat_lo_o}) == 1) |-> !match_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(index_o) && $stable(match_o) && $stable(pat_hi_o) && $stable(pat_lo_o));
endmodule

bind mac_hash_filter mhf_checker #(.TBL_W(TBL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .match_o(match_o), .index_o(index_o),
  .tbl_hi_i(tbl_hi_i), .tbl_lo_i(tbl_lo_i), .pat_hi_o(pat_hi_o), .pat_lo_o(pat_lo_o)
);

// File: tb/sim_mac_hash_filter.sv
`timescale 1ns/100ps
module sim_mac_hash_filter;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, byte_mode_i = 1'b0, pattern_mode_i = 1'b0;
  logic [47:0] addr_i = '0;
  logic [31:0] tbl_hi_i = '0, tbl_lo_i = '0;
  logic        busy_o, done_o, match_o;
  logic [5:0]  index_o;
  logic [31:0] pat_hi_o, pat_lo_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  mac_hash_filter u0 (.*);

  typedef struct packed {
    logic [47:0] addr;
    logic        bm;
    logic        pm;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
    '{48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF},
    '{48'h0000_0000_0000, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{48'h5544_3322_1100, 1'b1, 1'b0, 32'hA5A5_5A5A, 32'h0F0F_F0F0},
    '{48'h5544_3322_1100, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{48'h0100_005E_0001, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{48'h0100_005E_0001, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{48'h8000_0000_0001, 1'b1, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0}
  };

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      if (a[b] ^ c[0]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c[31:26];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one run; returns edges from the accepting edge to done; optional mid-run restart
  task automatic run(input logic [47:0] a, input bit bm, input bit pm,
                     input logic [31:0] hi, input logic [31:0] lo,
                     input bit disturb, output int lat);
    @(negedge clk_i);
    addr_i = a; byte_mode_i = bm; pattern_mode_i = pm;
    tbl_hi_i = hi; tbl_lo_i = lo; start_i = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk_i);
      lat++;
      start_i = 1'b0;
      if (lat == 1) chk(busy_o == 1'b1, "R4 busy after start", 64'(busy_o), 64'd1);
      if (disturb && lat == 2) begin
        start_i = 1'b1; addr_i = ~a; byte_mode_i = ~bm; pattern_mode_i = ~pm;
      end
      if (done_o || lat > 60) break;
    end
    lat = lat - 1;
  endtask

  task automatic judge(input logic [47:0] a, input bit bm, input bit pm,
                       input logic [31:0] hi, input logic [31:0] lo, input int lat);
    logic [5:0]  ei;
    logic [63:0] img, tbl;
    ei  = model_idx(a);
    tbl = {hi, lo};
    img = 64'd1 << ei;
    chk(index_o == ei, "R2 index", 64'(index_o), 64'(ei));
    chk(lat == (bm ? 6 : 48), "R3 latency", 64'(lat), bm ? 64'd6 : 64'd48);
    chk(busy_o == 1'b0, "R4 busy low at done", 64'(busy_o), 64'd0);
    if (pm) begin
      chk({pat_hi_o, pat_lo_o} == img, "R6 pattern", {pat_hi_o, pat_lo_o}, img);
      chk(match_o == 1'b0, "R6 no match", 64'(match_o), 64'd0);
    end else begin
      chk(match_o == tbl[ei], "R5 match", 64'(match_o), 64'(tbl[ei]));
      chk({pat_hi_o, pat_lo_o} == 64'd0, "R7 pattern zero", {pat_hi_o, pat_lo_o}, 64'd0);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R4 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [5:0] i1, i2, held;
    logic [47:0] ra;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, match_o, index_o, pat_hi_o, pat_lo_o} == '0, "R1 in reset", 64'(index_o), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({busy_o, done_o, match_o, index_o, pat_hi_o, pat_lo_o} == '0, "R1 after reset", 64'(busy_o), 64'd0);

    for (int v = 0; v < NV; v++) begin
      run(VECS[v].addr, VECS[v].bm, VECS[v].pm, VECS[v].hi, VECS[v].lo, 1'b0, lat);
      judge(VECS[v].addr, VECS[v].bm, VECS[v].pm, VECS[v].hi, VECS[v].lo, lat);
    end

    // R8: restart request and input changes during a byte-mode run
    ra = 48'h0A1B_2C3D_4E5F;
    run(ra, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 1'b1, lat);
    judge(ra, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, lat);
    chk(busy_o == 1'b0, "R8 restart not queued", 64'(busy_o), 64'd0);

    // R9: outputs hold with inputs moving and no start
    held = index_o;
    addr_i = ~addr_i; tbl_hi_i = ~tbl_hi_i; tbl_lo_i = ~tbl_lo_i;
    repeat (5) @(negedge clk_i);
    chk(index_o == held, "R9 hold", 64'(index_o), 64'(held));

    // R3: both stepping modes agree on random addresses; R5 with random tables
    for (int k = 0; k < 40; k++) begin
      logic [31:0] h, l;
      ra = {16'($urandom), $urandom};
      h = $urandom; l = $urandom;
      run(ra, 1'b1, 1'b0, h, l, 1'b0, lat);
      i1 = index_o;
      judge(ra, 1'b1, 1'b0, h, l, lat);
      run(ra, 1'b0, k[0], h, l, 1'b0, lat);
      i2 = index_o;
      judge(ra, 1'b0, k[0], h, l, lat);
      chk(i1 == i2, "R3 modes agree", 64'(i2), 64'(i1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule